// File: doc/BRIEF.md
# PCI Configuration Address Generator

This block is the host-side front end of configuration mechanism #1 for a PCI bus. Software loads a 32-bit configuration address word through an I/O port at 0CF8h: an enable bit, a target bus, a device, a function and a dword register index. An access to the data port at 0CFCh..0CFFh then makes the block translate that word into the address phase of a configuration cycle. The cycle is either Type 0, for a device on the local bus 0, or Type 1, for a device behind a bridge on another bus.

For a Type 0 cycle the device number is decoded into a one-hot IDSEL line among AD31..AD11. The function and register fields are placed below that line. For a Type 1 cycle the bus, device, function and register fields pass through unchanged, and the two low bits are marked 01b. One cycle after the data-port access, a single-cycle start strobe presents the AD word, the cycle type and the read/write direction to the bus sequencer. When the enable bit is clear, a data-port access starts no configuration cycle. It is flagged as an ordinary I/O access instead. Arbitration, the data phase and the downstream bridge belong to other blocks.

Top module: `cfg_addr_gen`

## Requirements
- R1: After a synchronous active-low reset, the address register reads back as zero, and neither `cfg_start` nor `io_fwd` is high.
- R2: A write to port 0CF8h with all four byte enables set stores the word with bits 30..24 and 1..0 forced to zero. A read of 0CF8h with all four byte enables set returns the stored word on `io_rdata` in the same cycle. A partial-width write to 0CF8h leaves the register unchanged. A partial-width read of 0CF8h returns zero.
- R3: A data-port access (word address 0CFCh, any byte enables) made while register bit 31 is zero raises `io_fwd` for one cycle, one cycle after the access, and does not raise `cfg_start`.
- R4: With bit 31 set and bus field (bits 23..16) equal to zero, a data-port access produces a Type 0 cycle (`cfg_type1` = 0). Device number n (bits 15..11) below 21 drives AD[11+n] high, and every other AD31..AD11 line stays low. AD10..AD8 carries the function (bits 10..8), AD7..AD2 carries the register index (bits 7..2), and AD1..AD0 = 00b.
- R5: In a Type 0 cycle, device numbers 21 to 31 leave all of AD31..AD11 low, and the cycle still starts.
- R6: With bit 31 set and a nonzero bus field, a data-port access produces a Type 1 cycle (`cfg_type1` = 1). AD31..AD24 = 0, AD23..AD2 carries bits 23..2 of the register unchanged, and AD1..AD0 = 01b.
- R7: `cfg_start` rises in the cycle after an enabled data-port access and lasts one cycle per access. `cfg_write` equals the access's `io_write`. The AD word reflects a register write made in the immediately preceding cycle.
- R8: Accesses to any other I/O address change no state and raise neither `cfg_start` nor `io_fwd`. `io_rdata` is zero for every read other than a full-width read of 0CF8h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_valid | input | 1 | I/O access present this cycle |
| io_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | I/O byte address |
| io_be | input | 4 | Byte enables |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Read data for the address port, zero otherwise |
| cfg_start | output | 1 | One-cycle start of a configuration cycle |
| cfg_write | output | 1 | Direction of the started cycle |
| cfg_type1 | output | 1 | 1 = Type 1 cycle, 0 = Type 0 |
| cfg_ad | output | 32 | Address-phase AD word |
| io_fwd | output | 1 | Data-port access passed on as ordinary I/O |

## Verification
The bench works through the IDSEL decode boundary. Devices 0 and 20 must hit AD11 and AD31. Devices 21 and 31 must leave every IDSEL line low; a decoder that wrapped or saturated would select a wrong device there. It separates bus 0 from buses 1 and 255, so that a type decision tested on only some bus bits shows up as a wrong cycle type. It also checks that bit 31 gates the cycle: a missed gate launches a cycle, and an over-eager gate loses the pass-through. Partial-width writes to 0CF8h must be ignored and reserved bits must be masked, and a register write followed at once by a data-port access must use the new word. A design with an extra pipeline stage would send the stale address there.

// File: rtl/cfg_pkg.sv
// Package: shared constants and the field layout of the configuration
// address word. The field positions follow the PCI mechanism #1 layout,
// which the bus sequencer and downstream bridges decode.
package cfg_pkg;

    localparam int unsigned CFG_W      = 32;
    localparam int unsigned DEV_W      = 5;
    localparam int unsigned IDSEL_LSB  = 11;
    localparam int unsigned IDSEL_CNT  = CFG_W - IDSEL_LSB;

    // Bits that software may set; reserved and low bits read as zero.
    localparam logic [CFG_W-1:0] WR_MASK = 32'h80FF_FFFC;

    typedef struct packed {
        logic       en;
        logic [6:0] rsvd;
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] fn;
        logic [5:0] dw;
        logic [1:0] lo;
    } cfg_word_t;

    localparam logic [1:0] LOW_TYPE0 = 2'b00;
    localparam logic [1:0] LOW_TYPE1 = 2'b01;

endpackage

// File: rtl/cfg_port_decode.sv
// Module: cfg_port_decode
// Decodes an I/O access into an address-port hit (full width only) and a
// data-port hit (any byte enables inside the data dword).
// Assumes at most one access per cycle, qualified by io_valid.
module cfg_port_decode #(
    parameter int unsigned       IO_AW     = 16,
    parameter logic [IO_AW-1:0]  ADDR_PORT = 16'h0CF8,
    parameter logic [IO_AW-1:0]  DATA_PORT = 16'h0CFC
) (
    input  logic             io_valid,
    input  logic [IO_AW-1:0] io_addr,
    input  logic [3:0]       io_be,
    output logic             addr_full_hit,
    output logic             data_hit
);
    localparam int unsigned WA_W = IO_AW - 2;
    localparam logic [WA_W-1:0] DATA_WA = DATA_PORT[IO_AW-1:2];

    // Match the address port exactly and only for full-width accesses.
    always_comb begin
        addr_full_hit = io_valid && (io_addr == ADDR_PORT) && (io_be == 4'hF);
    end

    // Match any byte lane of the data dword.
    always_comb begin
        data_hit = io_valid && (io_addr[IO_AW-1:2] == DATA_WA);
    end
endmodule

// File: rtl/cfg_addr_reg.sv
// Module: cfg_addr_reg
// Holds the configuration address word. Reserved and low bits are masked on
// write so they always read as zero. Cleared by reset (enable off).
module cfg_addr_reg
    import cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] q
);
    // Load the masked word on a full-width write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_en) begin
            q <= wdata & WR_MASK;
        end
    end
endmodule

// File: rtl/cfg_ad_builder.sv
// Module: cfg_ad_builder
// Combinational translation of the address word into the address-phase AD
// value and cycle type. Type 0 when the bus field is zero: one-hot IDSEL
// above the function field. Type 1 otherwise: fields passed through.
module cfg_ad_builder
    import cfg_pkg::*;
(
    input  logic [CFG_W-1:0] addr_word,
    output logic [CFG_W-1:0] ad,
    output logic             type1
);
    cfg_word_t              w;
    logic [IDSEL_CNT-1:0]   idsel;

    assign w = cfg_word_t'(addr_word);

    // One comparator per IDSEL line; devices beyond the last line hit none.
    for (genvar g = 0; g < IDSEL_CNT; g++) begin : g_idsel
        assign idsel[g] = (w.dev == DEV_W'(g));
    end

    // Pick the cycle type from the bus field.
    always_comb begin
        type1 = (w.bus != 8'd0);
    end

    // Assemble the AD word for the chosen type.
    always_comb begin
        if (type1) begin
            ad = {8'd0, w.bus, w.dev, w.fn, w.dw, LOW_TYPE1};
        end else begin
            ad = {idsel, w.fn, w.dw, LOW_TYPE0};
        end
    end
endmodule

// File: rtl/cfg_cycle_launch.sv
// Module: cfg_cycle_launch
// Registers the outcome of a data-port access: a one-cycle start strobe with
// AD word, type and direction when enabled, or a one-cycle pass-through flag
// when the enable bit is clear.
module cfg_cycle_launch
    import cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_hit,
    input  logic             enable,
    input  logic             io_write,
    input  logic [CFG_W-1:0] ad_next,
    input  logic             type1_next,
    output logic             cfg_start,
    output logic             cfg_write,
    output logic             cfg_type1,
    output logic [CFG_W-1:0] cfg_ad,
    output logic             io_fwd
);
    // Strobes: one per access, split by the enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_start <= 1'b0;
            io_fwd    <= 1'b0;
        end else begin
            cfg_start <= data_hit && enable;
            io_fwd    <= data_hit && !enable;
        end
    end

    // Cycle payload, captured only when a cycle is launched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_write <= 1'b0;
            cfg_type1 <= 1'b0;
            cfg_ad    <= '0;
        end else if (data_hit && enable) begin
            cfg_write <= io_write;
            cfg_type1 <= type1_next;
            cfg_ad    <= ad_next;
        end
    end
endmodule

// File: rtl/cfg_addr_gen.sv
// Module: cfg_addr_gen (top)
// Host-side configuration mechanism #1 front end: address port register,
// port decode, AD word builder and cycle launcher. Data-port reads return
// zero here; the data phase is handled elsewhere.
module cfg_addr_gen
    import cfg_pkg::*;
#(
    parameter int unsigned       IO_AW     = 16,
    parameter logic [IO_AW-1:0]  ADDR_PORT = 16'h0CF8,
    parameter logic [IO_AW-1:0]  DATA_PORT = 16'h0CFC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_valid,
    input  logic             io_write,
    input  logic [IO_AW-1:0] io_addr,
    input  logic [3:0]       io_be,
    input  logic [31:0]      io_wdata,
    output logic [31:0]      io_rdata,
    output logic             cfg_start,
    output logic             cfg_write,
    output logic             cfg_type1,
    output logic [31:0]      cfg_ad,
    output logic             io_fwd
);
    logic             addr_full_hit;
    logic             data_hit;
    logic [CFG_W-1:0] addr_q;
    logic [CFG_W-1:0] ad_next;
    logic             type1_next;

    cfg_port_decode #(
        .IO_AW     (IO_AW),
        .ADDR_PORT (ADDR_PORT),
        .DATA_PORT (DATA_PORT)
    ) u_decode (
        .io_valid      (io_valid),
        .io_addr       (io_addr),
        .io_be         (io_be),
        .addr_full_hit (addr_full_hit),
        .data_hit      (data_hit)
    );

    cfg_addr_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (addr_full_hit && io_write),
        .wdata (io_wdata),
        .q     (addr_q)
    );

    cfg_ad_builder u_build (
        .addr_word (addr_q),
        .ad        (ad_next),
        .type1     (type1_next)
    );

    cfg_cycle_launch u_launch (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_hit   (data_hit),
        .enable     (addr_q[CFG_W-1]),
        .io_write   (io_write),
        .ad_next    (ad_next),
        .type1_next (type1_next),
        .cfg_start  (cfg_start),
        .cfg_write  (cfg_write),
        .cfg_type1  (cfg_type1),
        .cfg_ad     (cfg_ad),
        .io_fwd     (io_fwd)
    );

    // Read mux: only a full-width read of the address port returns data.
    always_comb begin
        io_rdata = (addr_full_hit && !io_write) ? addr_q : '0;
    end
endmodule

// File: rtl/cfg_addr_gen_chk.sv
// Module: cfg_addr_gen_chk
// Protocol checker bound to cfg_addr_gen. Observes ports and the address
// register and checks the launch rules over time.
module cfg_addr_gen_chk #(
    parameter int unsigned       IO_AW     = 16,
    parameter logic [IO_AW-1:0]  DATA_PORT = 16'h0CFC
) (
    input logic             clk,
    input logic             rst_n,
    input logic             io_valid,
    input logic [IO_AW-1:0] io_addr,
    input logic             cfg_start,
    input logic             cfg_type1,
    input logic [31:0]      cfg_ad,
    input logic             io_fwd,
    input logic [31:0]      addr_q
);
    logic dport;
    assign dport = io_valid && (io_addr[IO_AW-1:2] == DATA_PORT[IO_AW-1:2]);

    // R2: reserved and low bits of the stored word stay zero
    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_q[30:24] == 7'd0) && (addr_q[1:0] == 2'b00));

    // R3: a disabled access never launches a cycle
    p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_start |-> $past(addr_q[31]));

    // R3: launch and pass-through never coincide
    p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_start && io_fwd));

    // R4: Type 0 address carries at most one IDSEL and low bits 00
    p_type0_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_start && !cfg_type1) |-> ($onehot0(cfg_ad[31:11]) && cfg_ad[1:0] == 2'b00));

    // R6: Type 1 address has low bits 01 and clear top byte
    p_type1_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_start && cfg_type1) |-> (cfg_ad[1:0] == 2'b01 && cfg_ad[31:24] == 8'd0));

    // R7: every launch follows a data-port access one cycle earlier
    p_start_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_start |-> $past(dport));

    // R8: pass-through only follows a data-port access
    p_fwd_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        io_fwd |-> $past(dport));
endmodule

bind cfg_addr_gen cfg_addr_gen_chk #(
    .IO_AW     (IO_AW),
    .DATA_PORT (DATA_PORT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_valid  (io_valid),
    .io_addr   (io_addr),
    .cfg_start (cfg_start),
    .cfg_type1 (cfg_type1),
    .cfg_ad    (cfg_ad),
    .io_fwd    (io_fwd),
    .addr_q    (addr_q)
);

// File: tb/cfg_addr_gen_bench.sv
module cfg_addr_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_valid = 1'b0;
    logic        io_write = 1'b0;
    logic [15:0] io_addr = '0;
    logic [3:0]  io_be = '0;
    logic [31:0] io_wdata = '0;
    logic [31:0] io_rdata;
    logic        cfg_start, cfg_write, cfg_type1, io_fwd;
    logic [31:0] cfg_ad;

    int checks = 0;
    int fails  = 0;
    logic [31:0] m_reg = '0;   // bench model of the address word
    bit done = 0;

    always #4 clk = ~clk;      // 125 MHz

    cfg_addr_gen u_cfg_addr_gen (
        .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_write(io_write),
        .io_addr(io_addr), .io_be(io_be), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .cfg_start(cfg_start), .cfg_write(cfg_write), .cfg_type1(cfg_type1),
        .cfg_ad(cfg_ad), .io_fwd(io_fwd)
    );

    function automatic logic [31:0] exp_ad(input logic [31:0] a);
        logic [31:0] r;
        if (a[23:16] == 8'd0) begin
            r = '0;
            if (a[15:11] < 5'd21) r[11 + a[15:11]] = 1'b1;
            r[10:2] = a[10:2];
        end else begin
            r = {8'd0, a[23:2], 2'b01};
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One access lasting one cycle; read data checked before the edge,
    // registered outputs checked after it.
    task automatic access(input bit wr, input logic [15:0] addr, input logic [3:0] be, input logic [31:0] wd);
        bit is_addr_full, is_data;
        logic [31:0] exp_rd;
        logic [31:0] pre;
        pre = m_reg;
        is_addr_full = (addr == 16'h0CF8) && (be == 4'hF);
        is_data = (addr[15:2] == 14'h033F);
        io_valid = 1'b1; io_write = wr; io_addr = addr; io_be = be; io_wdata = wd;
        #1;
        exp_rd = (is_addr_full && !wr) ? m_reg : 32'd0;
        chk(io_rdata == exp_rd, "R2/R8 rdata", io_rdata, exp_rd);
        @(posedge clk);
        if (is_addr_full && wr) m_reg = wd & 32'h80FF_FFFC;
        @(negedge clk);
        if (is_data && pre[31]) begin
            chk(cfg_start == 1'b1, "R7 start", 32'(cfg_start), 1);
            chk(cfg_write == wr, "R7 write", 32'(cfg_write), 32'(wr));
            chk(cfg_type1 == (pre[23:16] != 0), "R4/R6 type", 32'(cfg_type1), 32'(pre[23:16] != 0));
            chk(cfg_ad == exp_ad(pre), "R4/R5/R6 ad", cfg_ad, exp_ad(pre));
            chk(io_fwd == 1'b0, "R3 fwd", 32'(io_fwd), 0);
        end else if (is_data) begin
            chk(cfg_start == 1'b0 && io_fwd == 1'b1, "R3 gate", {cfg_start, io_fwd}, 32'b01);
        end else begin
            chk(cfg_start == 1'b0 && io_fwd == 1'b0, "R8 quiet", {cfg_start, io_fwd}, 0);
        end
        io_valid = 1'b0;
    endtask

    task automatic idle_chk();
        @(posedge clk); @(negedge clk);
        chk(cfg_start == 1'b0 && io_fwd == 1'b0, "R7 single", {cfg_start, io_fwd}, 0);
    endtask

    task automatic rd_reg();
        access(1'b0, 16'h0CF8, 4'hF, 32'h0);
        chk(1'b1, "R2 readback", 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(cfg_start == 0 && io_fwd == 0, "R1 strobes", {cfg_start, io_fwd}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_reg();                                       // R1: reads zero
        access(1'b1, 16'h0CFC, 4'hF, 32'h1);            // R3: disabled
        // R2: masking and partial writes
        access(1'b1, 16'h0CF8, 4'hF, 32'hFFFF_FFFF);
        rd_reg();
        access(1'b1, 16'h0CF8, 4'h3, 32'h0000_0000);    // ignored
        rd_reg();
        access(1'b0, 16'h0CF8, 4'h1, 32'h0);            // partial read -> 0
        // R4 / R5: IDSEL boundaries, back-to-back write then access
        for (int d = 0; d < 32; d++) begin
            access(1'b1, 16'h0CF8, 4'hF, 32'h8000_0000 | (d << 11) | (32'(d % 8) << 8) | 32'h54);
            access(d[0], 16'h0CFC + 16'(d % 4), 4'h1 << (d % 4), 32'h0);
        end
        idle_chk();
        // R6: Type 1 buses 1 and 255
        access(1'b1, 16'h0CF8, 4'hF, 32'h8001_FAFC);
        access(1'b0, 16'h0CFC, 4'hF, 32'h0);
        access(1'b1, 16'h0CF8, 4'hF, 32'h80FF_0004);
        access(1'b1, 16'h0CFE, 4'hC, 32'h0);
        idle_chk();
        // R8: other ports
        access(1'b1, 16'h0CF4, 4'hF, 32'h1234_5678);
        access(1'b0, 16'h0D00, 4'hF, 32'h0);
        rd_reg();
        // Random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            logic [31:0] v;
            op = $urandom_range(0, 5);
            v = $urandom();
            if ($urandom_range(0, 1) == 0) v[23:16] = 8'd0;
            case (op)
                0: access(1'b1, 16'h0CF8, 4'hF, v);
                1: access(1'b1, 16'h0CF8, 4'($urandom_range(0, 14)), v);
                2: rd_reg();
                3, 4: access(1'($urandom()), 16'h0CFC + 16'($urandom_range(0, 3)), 4'hF, v);
                default: access(1'($urandom()), 16'($urandom()), 4'hF, v);
            endcase
            if ($urandom_range(0, 3) == 0) idle_chk();
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule